// File: doc/BRIEF.md
# Configurable Four-Node Neural Processing Block

This block is one processing element of a grid-structured neural network. It owns four nodes, numbered 1 to 4. A 2-bit topology code splits them into input nodes and output nodes. The code gives one input feeding three outputs, three inputs feeding one output, or one of two arrangements with two inputs and two outputs. Seven directed weighted links join the nodes, and each of the three nodes 2, 3 and 4 carries a bias. When a run is started, each output node computes a clamped linear activation of its bias plus the weighted sum over the links that reach it from input nodes.

All products are formed by a single shared multiply-accumulate unit. A sequencer steps that unit through only the links that are active in the chosen topology, so a run takes fewer cycles when fewer links are in use. The topology code, seven weights and three biases arrive together as one 102-bit configuration word. They are captured into a weight bank, a bias bank and a topology register. Input values are sampled when a run starts. Outputs carry per-node valid flags, and a one-cycle done pulse marks the end of a run.

Top module: `lmx_neural_block`

## Requirements
- R1: A configuration word is captured when `cfg_load` is high in an idle cycle. Its fields are: topology code in bits [1:0]; link weights at bits [2+10k +: 10] for k = 0..6 in the link order 1→2, 1→3, 1→4, 3→2, 3→4, 4→2, 4→3; biases of nodes 2, 3, 4 at bits [72+10m +: 10] for m = 0, 1, 2. Port index n (0..3) stands for node n+1.
- R2: Topology codes select the input nodes as follows: 00 = node 1; 01 = nodes 1, 3, 4; 10 = nodes 1, 4; 11 = nodes 1, 3. Every other node is an output node.
- R3: Each output node j produces act(b_j·2^8 + Σ w_ij·x_i), where the sum runs over the links i→j whose source i is an input node. Data, weights and biases are signed 10-bit values with 8 fractional bits.
- R4: A link contributes nothing when its source is an output node or its destination is an input node, whatever its weight.
- R5: The activation takes the Q16 sum s and returns clamp(128 + floor(s / 1024), 0, 256). In other words it is 0.5 + s/4, clamped to [0, 1] in Q8 form.
- R6: `done` goes high exactly N clock edges after the edge that samples `start`. N is the sum over output nodes of (2 + number of active links into that node), which gives 9, 5, 8 and 8 cycles for codes 00, 01, 10 and 11.
- R7: `done` lasts one cycle. Starting a run clears all outputs and valid flags. At `done`, valid is set exactly on the output nodes, while input nodes read 0 with valid low.
- R8: `start` and `cfg_load` have no effect while a run is in progress.
- R9: After synchronous reset, all outputs, valid flags and `done` are 0, and the configuration is all zero (code 00, zero weights and biases).
- R10: Node inputs are sampled at the `start` edge, so changes during a run do not affect the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture `cfg_word` (idle only) |
| cfg_word | input | 102 | Topology code, weights and biases |
| start | input | 1 | Begin a run (idle only) |
| node_in | input | 4x10 | Signed node input values, index n = node n+1 |
| node_out | output | 4x10 | Activation results, Q8, 0..256 |
| node_valid | output | 4 | Result valid per node |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with its default 10-bit data width and 8 fractional bits. At these settings every field of the configuration word and every data value can be driven over its full signed range. That makes both clamp limits, the zero-input midpoint and the largest accumulated sums reachable. All four topology codes are swept with many random value sets. Directed cases place a single weight at each link position, load large weights on links that must be skipped, and disturb inputs and configuration mid-run.

// File: rtl/lmx_nb_pkg.sv
package lmx_nb_pkg;

    localparam int NODES  = 4;
    localparam int LINKS  = 7;
    localparam int BIASES = 3;
    localparam int TYPE_W = 2;

    typedef enum logic [1:0] {
        T_ONE_THREE = 2'b00,
        T_THREE_ONE = 2'b01,
        T_TWO_TWO_A = 2'b10,
        T_TWO_TWO_B = 2'b11
    } topo_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_MAC,
        S_WRITE
    } seq_state_e;

    // bit n set = node n+1 is an input node
    function automatic logic [NODES-1:0] input_mask(topo_e t);
        case (t)
            T_ONE_THREE: return 4'b0001;
            T_THREE_ONE: return 4'b1101;
            T_TWO_TWO_A: return 4'b1001;
            default:     return 4'b0101;
        endcase
    endfunction

    // nodes that own a link ending at dst
    function automatic logic [NODES-1:0] feed_mask(logic [1:0] dst);
        case (dst)
            2'd1:    return 4'b1101;
            2'd2:    return 4'b1001;
            2'd3:    return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    // weight slot of the directed link src -> dst
    function automatic logic [2:0] link_index(logic [1:0] src, logic [1:0] dst);
        case ({src, dst})
            4'b00_01: return 3'd0;
            4'b00_10: return 3'd1;
            4'b00_11: return 3'd2;
            4'b10_01: return 3'd3;
            4'b10_11: return 3'd4;
            4'b11_01: return 3'd5;
            4'b11_10: return 3'd6;
            default:  return 3'd0;
        endcase
    endfunction

    function automatic logic [1:0] lowest_node(logic [NODES-1:0] m);
        if (m[0])      return 2'd0;
        else if (m[1]) return 2'd1;
        else if (m[2]) return 2'd2;
        else           return 2'd3;
    endfunction

endpackage

// File: rtl/lmx_cfg_regs.sv
module lmx_cfg_regs
    import lmx_nb_pkg::*;
#(
    parameter int DATA_W = 10,
    localparam int CFG_W = TYPE_W + (LINKS + BIASES) * DATA_W,
    localparam int B_BASE = TYPE_W + LINKS * DATA_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [CFG_W-1:0]               word,
    output topo_e                          topo,
    output logic [LINKS-1:0][DATA_W-1:0]   weights,
    output logic [BIASES-1:0][DATA_W-1:0]  biases
);

    always_ff @(posedge clk) begin
        if (rst)       topo <= T_ONE_THREE;
        else if (load) topo <= topo_e'(word[TYPE_W-1:0]);
    end

    for (genvar k = 0; k < LINKS; k++) begin : g_wbank
        always_ff @(posedge clk) begin
            if (rst)       weights[k] <= '0;
            else if (load) weights[k] <= word[TYPE_W + k*DATA_W +: DATA_W];
        end
    end

    for (genvar m = 0; m < BIASES; m++) begin : g_bbank
        always_ff @(posedge clk) begin
            if (rst)       biases[m] <= '0;
            else if (load) biases[m] <= word[B_BASE + m*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/lmx_mac.sv
module lmx_mac #(
    parameter int DATA_W = 10,
    parameter int FRAC   = 8,
    parameter int ACC_W  = 2 * DATA_W + 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic signed [DATA_W-1:0] clr_val,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] wt,
    input  logic signed [DATA_W-1:0] dat,
    output logic signed [ACC_W-1:0]  acc
);

    logic signed [2*DATA_W-1:0] prod;
    logic signed [ACC_W-1:0]    seed;

    always_comb begin
        prod = wt * dat;
        seed = ACC_W'(clr_val) <<< FRAC;
    end

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (clr) acc <= seed;
        else if (en)  acc <= acc + ACC_W'(prod);
    end

endmodule

// File: rtl/lmx_sequencer.sv
module lmx_sequencer
    import lmx_nb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  topo_e      topo,
    output logic       idle,
    output logic       launch,
    output logic [1:0] node,
    output logic [1:0] src,
    output logic       mac_clr,
    output logic       mac_en,
    output logic       wr_en,
    output logic       done
);

    seq_state_e       state;
    logic [NODES-1:0] pend_out;
    logic [NODES-1:0] pend_src;
    logic [NODES-1:0] src_left;
    logic [NODES-1:0] out_left;

    always_comb begin
        node     = lowest_node(pend_out);
        src      = lowest_node(pend_src);
        idle     = (state == S_IDLE);
        launch   = idle && start;
        mac_clr  = (state == S_LOAD);
        mac_en   = (state == S_MAC);
        wr_en    = (state == S_WRITE);
        src_left = pend_src & ~(4'b0001 << src);
        out_left = pend_out & ~(4'b0001 << node);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            pend_out <= '0;
            pend_src <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        pend_out <= ~input_mask(topo);
                        state    <= S_LOAD;
                    end
                end
                S_LOAD: begin
                    pend_src <= input_mask(topo) & feed_mask(node);
                    state    <= S_MAC;
                end
                S_MAC: begin
                    pend_src <= src_left;
                    if (src_left == '0) state <= S_WRITE;
                end
                default: begin
                    pend_out <= out_left;
                    if (out_left == '0) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= S_LOAD;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lmx_neural_block.sv
module lmx_neural_block
    import lmx_nb_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int FRAC   = 8,
    localparam int CFG_W = TYPE_W + (LINKS + BIASES) * DATA_W,
    localparam int ACC_W = 2 * DATA_W + 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_load,
    input  logic [CFG_W-1:0]              cfg_word,
    input  logic                          start,
    input  logic [NODES-1:0][DATA_W-1:0]  node_in,
    output logic [NODES-1:0][DATA_W-1:0]  node_out,
    output logic [NODES-1:0]              node_valid,
    output logic                          done
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1) <<< FRAC;

    topo_e                          topo_q;
    logic [LINKS-1:0][DATA_W-1:0]   weights;
    logic [BIASES-1:0][DATA_W-1:0]  biases;
    logic [NODES-1:0][DATA_W-1:0]   x_q;
    logic                           seq_idle, launch, mac_clr, mac_en, wr_en;
    logic [1:0]                     node, src;
    logic signed [ACC_W-1:0]        acc, scaled, lifted;
    logic [DATA_W-1:0]              act, w_sel, d_sel, b_sel;

    lmx_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load && seq_idle),
        .word    (cfg_word),
        .topo    (topo_q),
        .weights (weights),
        .biases  (biases)
    );

    lmx_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .topo    (topo_q),
        .idle    (seq_idle),
        .launch  (launch),
        .node    (node),
        .src     (src),
        .mac_clr (mac_clr),
        .mac_en  (mac_en),
        .wr_en   (wr_en),
        .done    (done)
    );

    always_comb begin
        w_sel = weights[link_index(src, node)];
        d_sel = x_q[src];
        b_sel = biases[node - 2'd1];
    end

    lmx_mac #(.DATA_W(DATA_W), .FRAC(FRAC), .ACC_W(ACC_W)) u_mac (
        .clk     (clk),
        .rst     (rst),
        .clr     (mac_clr),
        .clr_val (b_sel),
        .en      (mac_en),
        .wt      (w_sel),
        .dat     (d_sel),
        .acc     (acc)
    );

    // piecewise-linear activation: 0.5 + s/4, clamped to [0, 1]
    always_comb begin
        scaled = acc >>> (FRAC + 2);
        lifted = scaled + HALF;
        if (lifted < 0)        act = '0;
        else if (lifted > ONE) act = ONE[DATA_W-1:0];
        else                   act = lifted[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q        <= '0;
            node_out   <= '0;
            node_valid <= '0;
        end else if (launch) begin
            x_q        <= node_in;
            node_out   <= '0;
            node_valid <= '0;
        end else if (wr_en) begin
            node_out[node]   <= act;
            node_valid[node] <= 1'b1;
        end
    end

endmodule

// File: rtl/lmx_neural_block_chk.sv
module lmx_neural_block_chk
    import lmx_nb_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int FRAC   = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         done,
    input logic                         seq_idle,
    input topo_e                        topo,
    input logic [NODES-1:0]             node_valid,
    input logic [NODES-1:0][DATA_W-1:0] node_out
);

    // R7: end-of-run pulse is a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: at done every output node is valid, no input node is
    a_r7_valid_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (node_valid == (~input_mask(topo) & 4'b1110)));

    // R2: input nodes never flag valid during or at the end of a run
    a_r2_inputs_quiet: assert property (@(posedge clk) disable iff (rst)
        (!seq_idle || done) |-> ((node_valid & input_mask(topo)) == '0));

    // R8: configuration holds while a run is in progress
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !seq_idle |=> $stable(topo));

    // R9: reset clears valid flags and done
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (node_valid == '0 && !done));

    // R5: activation results stay in [0, 1]
    for (genvar g = 0; g < NODES; g++) begin : g_rng
        a_r5_out_range: assert property (@(posedge clk) disable iff (rst)
            node_out[g] <= DATA_W'(1 << FRAC));
    end

endmodule

bind lmx_neural_block lmx_neural_block_chk #(.DATA_W(DATA_W), .FRAC(FRAC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .seq_idle   (seq_idle),
    .topo       (topo_q),
    .node_valid (node_valid),
    .node_out   (node_out)
);

// File: tb/lmx_neural_block_test.sv
module lmx_neural_block_test;

    localparam int DW = 10;
    localparam int CW = 102;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_load = 1'b0;
    logic [CW-1:0]     cfg_word = '0;
    logic              start = 1'b0;
    logic [3:0][DW-1:0] node_in = '0;
    logic [3:0][DW-1:0] node_out;
    logic [3:0]        node_valid;
    logic              done;

    int nvec = 0;
    int nbad = 0;

    int t;
    int w[7];
    int b[3];
    int xv[4];
    // link k: source node index, destination node index (0 = node 1)
    int lsrc[7] = '{0, 0, 0, 2, 2, 3, 3};
    int ldst[7] = '{1, 2, 3, 1, 3, 1, 2};

    always #4 clk = ~clk;

    lmx_neural_block uut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .start(start), .node_in(node_in), .node_out(node_out),
        .node_valid(node_valid), .done(done)
    );

    task automatic chk(string req, string what, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_in(int n);
        case (t)
            0: return n == 0;
            1: return n != 1;
            2: return n == 0 || n == 3;
            default: return n == 0 || n == 2;
        endcase
    endfunction

    function automatic int model_y(int j);
        int s;
        int q;
        if (is_in(j)) return 0;
        s = b[j-1] * 256;
        for (int k = 0; k < 7; k++)
            if (ldst[k] == j && is_in(lsrc[k])) s += w[k] * xv[lsrc[k]];
        q = (s >>> 10) + 128;
        if (q < 0) q = 0;
        if (q > 256) q = 256;
        return q;
    endfunction

    function automatic int model_lat();
        int n = 0;
        for (int j = 1; j < 4; j++)
            if (!is_in(j)) begin
                n += 2;
                for (int k = 0; k < 7; k++)
                    if (ldst[k] == j && is_in(lsrc[k])) n++;
            end
        return n;
    endfunction

    function automatic logic [CW-1:0] make_word();
        logic [CW-1:0] wd = '0;
        wd[1:0] = t[1:0];
        for (int k = 0; k < 7; k++) wd[2 + 10*k +: 10] = w[k][9:0];
        for (int m = 0; m < 3; m++) wd[72 + 10*m +: 10] = b[m][9:0];
        return wd;
    endfunction

    task automatic load_cfg();
        @(negedge clk);
        cfg_word = make_word();
        cfg_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // disturb: change inputs, try a new config and a new start mid-run
    task automatic run(string yreq, bit disturb);
        int cnt = 0;
        @(negedge clk);
        for (int n = 0; n < 4; n++) node_in[n] = xv[n][9:0];
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            for (int n = 0; n < 4; n++) node_in[n] = ~node_in[n];
            cfg_word = ~make_word();
            cfg_load = 1'b1;
            start = 1'b1;
        end
        while (cnt < 64) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1) begin
                cfg_load = 1'b0;
                start = 1'b0;
            end
            if (done) break;
        end
        chk("R6", "latency", cnt, model_lat());
        for (int n = 0; n < 4; n++) begin
            chk(yreq, $sformatf("node %0d value", n + 1), int'(node_out[n]), model_y(n));
            chk("R7", $sformatf("node %0d valid", n + 1), int'(node_valid[n]), is_in(n) ? 0 : 1);
        end
        @(negedge clk);
        chk("R7", "done pulse width", int'(done), 0);
    endtask

    task automatic set_all(int wv, int bv, int xval);
        for (int k = 0; k < 7; k++) w[k] = wv;
        for (int m = 0; m < 3; m++) b[m] = bv;
        for (int n = 0; n < 4; n++) xv[n] = xval;
    endtask

    function automatic int rnd();
        return int'($urandom_range(1023)) - 512;
    endfunction

    initial begin
        #(8 * 200000);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9", "done after reset", int'(done), 0);
        chk("R9", "valid after reset", int'(node_valid), 0);
        chk("R9", "outputs after reset", int'(node_out == '0), 1);
        t = 0;
        set_all(0, 0, 100);
        run("R9", 1'b0);

        for (int ty = 0; ty < 4; ty++) begin
            t = ty;
            // R1 field positions: one weight of 1.0 at a time
            for (int k = 0; k < 7; k++) begin
                set_all(0, 0, 256);
                w[k] = 256;
                load_cfg();
                run("R1", 1'b0);
            end
            // R5 clamp limits and midpoint, R2 node roles
            set_all(511, 511, 511);
            load_cfg();
            run("R5", 1'b0);
            set_all(511, -512, -512);
            load_cfg();
            run("R5", 1'b0);
            set_all(0, 0, 0);
            load_cfg();
            run("R2", 1'b0);
            // R4 skipped links carry big weights, used links zero
            set_all(0, 64, 400);
            for (int k = 0; k < 7; k++)
                if (!is_in(lsrc[k]) || is_in(ldst[k])) w[k] = 511;
            load_cfg();
            run("R4", 1'b0);
            // R3 random sweep
            for (int trial = 0; trial < 60; trial++) begin
                for (int k = 0; k < 7; k++) w[k] = rnd();
                for (int m = 0; m < 3; m++) b[m] = rnd();
                for (int n = 0; n < 4; n++) xv[n] = rnd();
                load_cfg();
                run("R3", 1'b0);
            end
            // R10 / R8: disturb mid-run, then rerun with kept config
            for (int n = 0; n < 4; n++) xv[n] = rnd();
            run("R10", 1'b1);
            run("R8", 1'b0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule